// File: doc/BRIEF.md
# Three-Master Burst Bus Controller

This block sits between three bus masters and two memory-mapped slaves on one synchronous bus. A master posts a request by holding its request line high. The request carries these fields:

- a direction (read or write)
- a start address
- a burst length in words
- a lock flag

All of these fields stay stable until the burst ends. The write data is the only field a master may change, and it changes once per word. The controller chooses one master by fixed priority. It decodes each word's address against two inclusive address windows and drives the selected slave. One word moves in each cycle in which the selected slave reports ready. The controller returns a per-master status code, and for reads it returns the word just read.

Slave 0 is a zero-wait-state slave and keeps its ready line high. Slave 1 holds ready low for a number of cycles before it completes each word. A master may set the lock flag on a burst. If it does, it keeps the bus for its next request, even when a higher-priority master is waiting.

Top module: `busCtrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, every master status reads IDLE (0) and no slave select is high.
- R2: Among eligible requesters, the master with the highest index is granted, and only one master owns the bus at a time. A master that is requesting but does not own the bus shows status REQUEST (1). A master that is not requesting shows status IDLE (0).
- R3: A burst of length L moves L words, at addresses start, start+1, …, start+L-1. Each completed word shows status OK (3) for one cycle on the next cycle. A read word appears on that master's read-data output in the same cycle as its OK.
- R4: Slave 0 is selected only for addresses in the range S0_BASE..S0_LAST, and slave 1 only for addresses in the range S1_BASE..S1_LAST. At most one slave select is high at a time.
- R5: A word whose address lies in neither window selects no slave. It completes at once with status ERROR (4) and ends the burst.
- R6: While the selected slave holds ready low, the word's address and select stay unchanged and the owner's status reads WAIT (2). With W wait cycles per word, a burst of L words takes L*(W+1) cycles.
- R7: After a locked burst ends, the same master's next request is granted before any other master's, including a higher-priority one. The bus stays with the owner during the cycle in which the owner's final status is showing.
- R8: A lock ends in two cases. First, when the owner's next request has its lock flag clear; that request is served and the lock then ends. Second, when the owner does not request for one full cycle; another master can then be granted in that same cycle.
- R9: The first word of a newly granted burst is moved in the same cycle the request is seen. A master whose final OK or ERROR status is showing is not eligible for a grant in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mReq | input | NUM_M | Per-master request, held until the burst ends |
| mWrite | input | NUM_M | Per-master direction, 1 = write |
| mLock | input | NUM_M | Per-master lock flag for the requested burst |
| mAddr | input | NUM_M*AW | Per-master burst start address |
| mLen | input | NUM_M*LW | Per-master burst length in words (0 is treated as 1) |
| mWdata | input | NUM_M*DW | Per-master write data for the current word |
| mStatus | output | NUM_M*3 | Per-master status: 0 IDLE, 1 REQUEST, 2 WAIT, 3 OK, 4 ERROR |
| mRdata | output | NUM_M*DW | Per-master read data, valid with OK after a read word |
| sSel | output | 2 | Slave selects, bit 0 for slave 0 and bit 1 for slave 1 |
| sWrite | output | 1 | Direction of the current word |
| sAddr | output | AW | Address of the current word |
| sWdata | output | DW | Write data of the current word |
| sRdata | input | 2*DW | Read data from each slave |
| sReady | input | 2 | Per-slave ready, completes the current word |

## Verification
The bench runs a near-exhaustive sweep of write bursts followed by read-back bursts. The sweep covers every master, both slaves and every length from 1 to 4. It checks the data, the target addresses, the cycle count and the number of WAIT cycles. This separates the zero-wait slave from the wait-state slave, and off-by-one errors in the address step from errors in the length count.

Further patterns cover contention:
- Simultaneous requests show the priority order and the REQUEST status.
- A back-to-back follow-up from an unlocked master shows that a master is excluded in its finishing cycle.
- Locked and unlocked runs of the same scenario are compared by completion order and by the gap between completions, which isolates the lock hold and the two ways a lock ends.

Bursts into the gap between the windows, and bursts that run off the end of a window, check error termination.

// File: rtl/busCtrlPkg.sv
`timescale 1ns/1ps
package busCtrlPkg;
  localparam int ID_W = 2;  // supports up to four masters

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_WAIT = 3'd2,
    ST_OK   = 3'd3,
    ST_ERR  = 3'd4
  } stat_e;

  // who owns this cycle's word
  typedef struct packed {
    logic            active;
    logic            grantNew;
    logic [ID_W-1:0] id;
  } selStrb_t;

  // how this cycle's word ends
  typedef struct packed {
    logic beatDone;
    logic decErr;
    logic endBurst;
  } stepStrb_t;
endpackage

// File: rtl/busCtrlArb.sv
`timescale 1ns/1ps
module busCtrlArb
  import busCtrlPkg::*;
#(
  parameter int NUM_M = 3,
  parameter int LW    = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_M-1:0]          mReq,
  input  logic [NUM_M-1:0]          mLock,
  input  logic [NUM_M-1:0][LW-1:0]  mLen,
  input  logic [1:0]                decHit,
  input  logic [1:0]                sReady,
  output selStrb_t                  sel,
  output stepStrb_t                 step,
  output logic [NUM_M-1:0][2:0]     mStatus
);
  logic             busy;
  logic [ID_W-1:0]  owner;
  logic [LW-1:0]    remain;
  logic             lockValid;
  logic [ID_W-1:0]  lockId;
  logic [NUM_M-1:0] lastMask;

  logic [NUM_M-1:0] eligible;
  logic             ownerReady, ownerHold, anyWin;
  logic [ID_W-1:0]  winner;
  logic [LW-1:0]    curLen;

  // fixed-priority pick, with the lock owner first
  always_comb begin
    eligible   = mReq & ~lastMask;
    ownerReady = lockValid & eligible[lockId];
    ownerHold  = lockValid & lastMask[lockId];
    anyWin     = 1'b0;
    winner     = '0;
    if (ownerReady) begin
      anyWin = 1'b1;
      winner = lockId;
    end else if (!ownerHold) begin
      for (int i = 0; i < NUM_M; i++) begin
        if (eligible[i]) begin
          anyWin = 1'b1;
          winner = ID_W'(i);
        end
      end
    end
  end

  always_comb begin
    sel.active   = busy | anyWin;
    sel.grantNew = ~busy & anyWin;
    sel.id       = busy ? owner : winner;
    if (busy)                   curLen = remain;
    else if (mLen[winner] == '0) curLen = LW'(1);
    else                        curLen = mLen[winner];
    step.decErr   = sel.active & ~(|decHit);
    step.beatDone = sel.active & (step.decErr | (|(decHit & sReady)));
    step.endBurst = step.beatDone & (step.decErr | (curLen <= LW'(1)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      owner     <= '0;
      remain    <= '0;
      lockValid <= 1'b0;
      lockId    <= '0;
      lastMask  <= '0;
    end else begin
      lastMask <= '0;
      if (step.endBurst) begin
        busy             <= 1'b0;
        lastMask[sel.id] <= 1'b1;
      end else if (sel.active) begin
        busy   <= 1'b1;
        owner  <= sel.id;
        remain <= step.beatDone ? curLen - LW'(1) : curLen;
      end
      if (sel.grantNew) begin
        lockValid <= mLock[winner];
        lockId    <= winner;
      end else if (!busy && lockValid && !ownerHold && !eligible[lockId]) begin
        lockValid <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NUM_M; g++) begin : gStat
    always_ff @(posedge clk) begin
      if (!rstN)                                      mStatus[g] <= ST_IDLE;
      else if (step.beatDone && sel.id == ID_W'(g))   mStatus[g] <= step.decErr ? ST_ERR : ST_OK;
      else if (sel.active && sel.id == ID_W'(g))      mStatus[g] <= ST_WAIT;
      else if (mReq[g])                               mStatus[g] <= ST_REQ;
      else                                            mStatus[g] <= ST_IDLE;
    end
  end
endmodule

// File: rtl/busCtrlPath.sv
`timescale 1ns/1ps
module busCtrlPath
  import busCtrlPkg::*;
#(
  parameter int          NUM_M   = 3,
  parameter int          AW      = 8,
  parameter int          DW      = 8,
  parameter int unsigned S0_BASE = 0,
  parameter int unsigned S0_LAST = 31,
  parameter int unsigned S1_BASE = 64,
  parameter int unsigned S1_LAST = 95
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  selStrb_t                  sel,
  input  stepStrb_t                 step,
  input  logic [NUM_M-1:0]          mWrite,
  input  logic [NUM_M-1:0][AW-1:0]  mAddr,
  input  logic [NUM_M-1:0][DW-1:0]  mWdata,
  input  logic [1:0][DW-1:0]        sRdata,
  output logic [1:0]                decHit,
  output logic [1:0]                sSel,
  output logic                      sWrite,
  output logic [AW-1:0]             sAddr,
  output logic [DW-1:0]             sWdata,
  output logic [NUM_M-1:0][DW-1:0]  mRdata
);
  localparam logic [AW-1:0] B0 = AW'(S0_BASE);
  localparam logic [AW-1:0] L0 = AW'(S0_LAST);
  localparam logic [AW-1:0] B1 = AW'(S1_BASE);
  localparam logic [AW-1:0] L1 = AW'(S1_LAST);

  function automatic logic inWin(input logic [AW-1:0] a, input logic [AW-1:0] lo,
                                 input logic [AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  logic [AW-1:0] curAddr, actAddr;

  always_comb begin
    actAddr   = sel.grantNew ? mAddr[sel.id] : curAddr;
    decHit[0] = inWin(actAddr, B0, L0);
    decHit[1] = inWin(actAddr, B1, L1) & ~decHit[0];
    sSel      = sel.active ? decHit : 2'b00;
    sAddr     = actAddr;
    sWrite    = mWrite[sel.id];
    sWdata    = mWdata[sel.id];
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                curAddr <= '0;
    else if (step.beatDone && !step.endBurst) curAddr <= actAddr + AW'(1);
    else if (sel.active && !step.beatDone)    curAddr <= actAddr;
  end

  for (genvar g = 0; g < NUM_M; g++) begin : gRd
    always_ff @(posedge clk) begin
      if (!rstN)
        mRdata[g] <= '0;
      else if (step.beatDone && !step.decErr && !mWrite[g] && sel.id == ID_W'(g))
        mRdata[g] <= decHit[1] ? sRdata[1] : sRdata[0];
    end
  end
endmodule

// File: rtl/busCtrl.sv
`timescale 1ns/1ps
module busCtrl
  import busCtrlPkg::*;
#(
  parameter int          NUM_M   = 3,
  parameter int          AW      = 8,
  parameter int          DW      = 8,
  parameter int          LW      = 4,
  parameter int unsigned S0_BASE = 0,
  parameter int unsigned S0_LAST = 31,
  parameter int unsigned S1_BASE = 64,
  parameter int unsigned S1_LAST = 95
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_M-1:0]          mReq,
  input  logic [NUM_M-1:0]          mWrite,
  input  logic [NUM_M-1:0]          mLock,
  input  logic [NUM_M-1:0][AW-1:0]  mAddr,
  input  logic [NUM_M-1:0][LW-1:0]  mLen,
  input  logic [NUM_M-1:0][DW-1:0]  mWdata,
  output logic [NUM_M-1:0][2:0]     mStatus,
  output logic [NUM_M-1:0][DW-1:0]  mRdata,
  output logic [1:0]                sSel,
  output logic                      sWrite,
  output logic [AW-1:0]             sAddr,
  output logic [DW-1:0]             sWdata,
  input  logic [1:0][DW-1:0]        sRdata,
  input  logic [1:0]                sReady
);
  selStrb_t   sel;
  stepStrb_t  step;
  logic [1:0] decHit;

  busCtrlArb #(.NUM_M(NUM_M), .LW(LW)) uArb (
    .clk(clk), .rstN(rstN), .mReq(mReq), .mLock(mLock), .mLen(mLen),
    .decHit(decHit), .sReady(sReady), .sel(sel), .step(step), .mStatus(mStatus)
  );

  busCtrlPath #(
    .NUM_M(NUM_M), .AW(AW), .DW(DW),
    .S0_BASE(S0_BASE), .S0_LAST(S0_LAST), .S1_BASE(S1_BASE), .S1_LAST(S1_LAST)
  ) uPath (
    .clk(clk), .rstN(rstN), .sel(sel), .step(step), .mWrite(mWrite),
    .mAddr(mAddr), .mWdata(mWdata), .sRdata(sRdata), .decHit(decHit),
    .sSel(sSel), .sWrite(sWrite), .sAddr(sAddr), .sWdata(sWdata), .mRdata(mRdata)
  );
endmodule

// File: rtl/busCtrlChk.sv
`timescale 1ns/1ps
module busCtrlChk #(
  parameter int          NUM_M   = 3,
  parameter int          AW      = 8,
  parameter int unsigned S0_BASE = 0,
  parameter int unsigned S0_LAST = 31,
  parameter int unsigned S1_BASE = 64,
  parameter int unsigned S1_LAST = 95
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_M-1:0][2:0] mStatus,
  input logic [1:0]            sSel,
  input logic [AW-1:0]         sAddr,
  input logic [1:0]            sReady
);
  function automatic logic inWin(input logic [AW-1:0] a, input logic [AW-1:0] lo,
                                 input logic [AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  logic [NUM_M-1:0] ownMask;
  logic             in0, in1;
  always_comb begin
    for (int i = 0; i < NUM_M; i++)
      ownMask[i] = (mStatus[i] == 3'd2) || (mStatus[i] == 3'd3) || (mStatus[i] == 3'd4);
    in0 = inWin(sAddr, AW'(S0_BASE), AW'(S0_LAST));
    in1 = inWin(sAddr, AW'(S1_BASE), AW'(S1_LAST));
  end

  a_r2_single_owner: assert property (@(posedge clk) disable iff (!rstN)
    $countones(ownMask) <= 1);

  a_r4_sel_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sSel));

  a_r4_sel0_range: assert property (@(posedge clk) disable iff (!rstN)
    sSel[0] |-> in0);

  a_r4_sel1_range: assert property (@(posedge clk) disable iff (!rstN)
    sSel[1] |-> in1);

  a_r6_wait_hold: assert property (@(posedge clk) disable iff (!rstN)
    (sSel[1] && !sReady[1]) |=> (sSel[1] && $stable(sAddr)));

  for (genvar g = 0; g < NUM_M; g++) begin : gErr
    a_r5_err_no_sel: assert property (@(posedge clk) disable iff (!rstN)
      (mStatus[g] == 3'd4) |-> ($past(sSel) == 2'b00));
  end
endmodule

bind busCtrl busCtrlChk #(
  .NUM_M(NUM_M), .AW(AW),
  .S0_BASE(S0_BASE), .S0_LAST(S0_LAST), .S1_BASE(S1_BASE), .S1_LAST(S1_LAST)
) uChk (
  .clk(clk), .rstN(rstN), .mStatus(mStatus), .sSel(sSel), .sAddr(sAddr), .sReady(sReady)
);

// File: tb/tb_busCtrl.sv
`timescale 1ns/1ps
module tb_busCtrl;
  localparam int NM = 3;
  localparam int W1 = 2;  // wait cycles of slave 1 per word

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [NM-1:0]          mReq = '0, mWrite = '0, mLock = '0;
  logic [NM-1:0][7:0]     mAddr = '0;
  logic [NM-1:0][3:0]     mLen = '0;
  logic [NM-1:0][7:0]     mWdata = '0;
  logic [NM-1:0][2:0]     mStatus;
  logic [NM-1:0][7:0]     mRdata;
  logic [1:0]             sSel;
  logic                   sWrite;
  logic [7:0]             sAddr, sWdata;
  logic [1:0][7:0]        sRdata;
  logic [1:0]             sReady;

  busCtrl dut (
    .clk(clk), .rstN(rstN), .mReq(mReq), .mWrite(mWrite), .mLock(mLock),
    .mAddr(mAddr), .mLen(mLen), .mWdata(mWdata), .mStatus(mStatus), .mRdata(mRdata),
    .sSel(sSel), .sWrite(sWrite), .sAddr(sAddr), .sWdata(sWdata),
    .sRdata(sRdata), .sReady(sReady)
  );

  // slave models: slave 0 zero-wait, slave 1 with W1 wait cycles
  logic [7:0] mem0 [32];
  logic [7:0] mem1 [32];
  int waitCnt = 0;
  always_comb begin
    sReady[0] = 1'b1;
    sReady[1] = (waitCnt == W1);
    sRdata[0] = mem0[sAddr[4:0]];
    sRdata[1] = mem1[sAddr[4:0]];
  end
  always @(posedge clk) begin
    if (sSel[1] && !sReady[1]) waitCnt <= waitCnt + 1;
    else                       waitCnt <= 0;
    if (sSel[0] && sWrite)              mem0[sAddr[4:0]] <= sWdata;
    if (sSel[1] && sReady[1] && sWrite) mem1[sAddr[4:0]] <= sWdata;
  end

  int total = 0, bad = 0, cycles = 0, seq = 0;
  int beats[NM], bLen[NM], bTag[NM], doneCnt[NM], errCnt[NM], waitSeen[NM];
  int reqCyc[NM], doneCyc[NM];
  logic [7:0] bAddr[NM];
  bit bWr[NM];
  int orderLog[8];
  bit hasNext[NM], nWr[NM], nLk[NM];
  logic [7:0] nAddr[NM];
  int nLen[NM], nTag[NM];

  function automatic logic [7:0] pat(input logic [7:0] a, input int t);
    return a * 8'd13 + 8'(t);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic load(input int i, input bit wr, input bit lk, input logic [7:0] a,
                      input int len, input int tag);
    mWrite[i] = wr; mLock[i] = lk; mAddr[i] = a; mLen[i] = 4'(len);
    mWdata[i] = pat(a, tag);
    bAddr[i] = a; bLen[i] = len; bTag[i] = tag; bWr[i] = wr;
    beats[i] = 0; waitSeen[i] = 0; errCnt[i] = 0; reqCyc[i] = cycles;
    mReq[i] = 1'b1;
  endtask

  task automatic finish(input int i);
    doneCnt[i]++;
    doneCyc[i] = cycles;
    if (seq < 8) orderLog[seq] = i;
    seq++;
    if (hasNext[i]) begin
      hasNext[i] = 0;
      load(i, nWr[i], nLk[i], nAddr[i], nLen[i], nTag[i]);
    end else begin
      mReq[i] = 1'b0;
    end
  endtask

  // one cycle of the master models, sampled at the falling edge
  task automatic stepCycle();
    @(negedge clk);
    cycles++;
    for (int i = 0; i < NM; i++) begin
      case (mStatus[i])
        3'd3: begin
          if (!bWr[i])
            chk("R3", "read word", int'(mRdata[i]), int'(pat(bAddr[i] + 8'(beats[i]), bTag[i])));
          beats[i]++;
          if (beats[i] >= bLen[i]) finish(i);
          else mWdata[i] = pat(bAddr[i] + 8'(beats[i]), bTag[i]);
        end
        3'd4: begin errCnt[i]++; finish(i); end
        3'd2: waitSeen[i]++;
        default: ;
      endcase
    end
  endtask

  task automatic waitDone();
    for (int k = 0; k < 300 && mReq != '0; k++) stepCycle();
    stepCycle();
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NM; i++) begin
      beats[i] = 0; bLen[i] = 1; bTag[i] = 0; doneCnt[i] = 0; errCnt[i] = 0;
      waitSeen[i] = 0; reqCyc[i] = 0; doneCyc[i] = 0; bAddr[i] = '0; bWr[i] = 0;
      hasNext[i] = 0; nWr[i] = 0; nLk[i] = 0; nAddr[i] = '0; nLen[i] = 1; nTag[i] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R1", "status during reset", int'(mStatus), 0);
    chk("R1", "select during reset", int'(sSel), 0);
    rstN = 1'b1;
    stepCycle();
    chk("R1", "status after reset", int'(mStatus), 0);
    chk("R1", "select after reset", int'(sSel), 0);

    // sweep: every master, both slaves, lengths 1..4, write then read back
    for (int i = 0; i < NM; i++) begin
      for (int s = 0; s < 2; s++) begin
        for (int len = 1; len <= 4; len++) begin
          logic [7:0] base;
          int per;
          base = (s == 1) ? 8'(64 + i * 8) : 8'(i * 8);
          per  = (s == 1) ? W1 + 1 : 1;
          load(i, 1'b1, 1'b0, base, len, i * 16 + len);
          waitDone();
          chk("R9", "write burst cycles", doneCyc[i] - reqCyc[i], len * per);
          chk("R3", "write words", beats[i], len);
          chk("R6", "write WAIT cycles", waitSeen[i], len * (per - 1));
          for (int k = 0; k < len; k++)
            chk("R4", "slave memory word",
                int'((s == 1) ? mem1[5'(base) + 5'(k)] : mem0[5'(base) + 5'(k)]),
                int'(pat(base + 8'(k), i * 16 + len)));
          load(i, 1'b0, 1'b0, base, len, i * 16 + len);
          waitDone();
          chk("R6", "read burst cycles", doneCyc[i] - reqCyc[i], len * per);
          chk("R3", "read words", beats[i], len);
          chk("R2", "idle after burst", int'(mStatus[i]), 0);
        end
      end
    end

    // priority: all three at once
    seq = 0;
    load(0, 1'b1, 1'b0, 8'h10, 1, 1);
    load(1, 1'b1, 1'b0, 8'h11, 1, 2);
    load(2, 1'b1, 1'b0, 8'h12, 1, 3);
    stepCycle();
    chk("R2", "master2 first OK", int'(mStatus[2]), 3);
    chk("R2", "master1 REQUEST", int'(mStatus[1]), 1);
    chk("R2", "master0 REQUEST", int'(mStatus[0]), 1);
    waitDone();
    chk("R2", "order first", orderLog[0], 2);
    chk("R2", "order second", orderLog[1], 1);
    chk("R2", "order third", orderLog[2], 0);

    // done-cycle exclusion: unlocked follow-up from master2 yields to master1
    seq = 0;
    hasNext[2] = 1; nWr[2] = 1; nLk[2] = 0; nAddr[2] = 8'h14; nLen[2] = 1; nTag[2] = 5;
    load(2, 1'b1, 1'b0, 8'h13, 1, 4);
    load(1, 1'b1, 1'b0, 8'h15, 1, 6);
    waitDone();
    chk("R9", "excl order 0", orderLog[0], 2);
    chk("R9", "excl order 1", orderLog[1], 1);
    chk("R9", "excl order 2", orderLog[2], 2);

    // lock held across a higher-priority request
    seq = 0;
    hasNext[0] = 1; nWr[0] = 1; nLk[0] = 0; nAddr[0] = 8'h52; nLen[0] = 1; nTag[0] = 7;
    load(0, 1'b1, 1'b1, 8'h50, 2, 8);
    stepCycle();
    load(2, 1'b1, 1'b0, 8'h08, 1, 9);
    waitDone();
    chk("R7", "locked order 0", orderLog[0], 0);
    chk("R7", "locked order 1", orderLog[1], 0);
    chk("R8", "after lock clear", orderLog[2], 2);

    // same scenario without the lock: higher priority gets in
    seq = 0;
    hasNext[0] = 1; nWr[0] = 1; nLk[0] = 0; nAddr[0] = 8'h52; nLen[0] = 1; nTag[0] = 7;
    load(0, 1'b1, 1'b0, 8'h50, 2, 8);
    stepCycle();
    load(2, 1'b1, 1'b0, 8'h08, 1, 9);
    waitDone();
    chk("R7", "unlocked order 1", orderLog[1], 2);
    chk("R7", "unlocked order 2", orderLog[2], 0);

    // lock ends after one idle cycle of the owner
    load(0, 1'b1, 1'b1, 8'h44, 1, 10);
    stepCycle();
    load(1, 1'b1, 1'b0, 8'h06, 1, 11);
    waitDone();
    chk("R8", "idle release gap", doneCyc[1] - doneCyc[0], 2);
    load(0, 1'b1, 1'b0, 8'h44, 1, 10);
    stepCycle();
    load(1, 1'b1, 1'b0, 8'h06, 1, 11);
    waitDone();
    chk("R7", "unlocked gap", doneCyc[1] - doneCyc[0], 1);

    // unmapped address
    load(1, 1'b0, 1'b0, 8'h30, 2, 12);
    stepCycle();
    chk("R5", "unmapped ERROR", int'(mStatus[1]), 4);
    chk("R5", "unmapped words", beats[1], 0);
    stepCycle();
    chk("R5", "idle after error", int'(mStatus[1]), 0);

    // burst running off the end of slave 0
    load(0, 1'b1, 1'b0, 8'h1E, 4, 13);
    waitDone();
    chk("R5", "words before error", beats[0], 2);
    chk("R5", "error count", errCnt[0], 1);
    chk("R5", "cycles to error", doneCyc[0] - reqCyc[0], 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule